// File: doc/BRIEF.md
# Serial Daisy-Chain Configuration Forwarder

This block is the per-device front end of a serial configuration chain. Every device in the chain shares one configuration clock and one active-low program line, so all devices restart together and stay in step with the bit stream. After a program pulse the block searches the incoming stream for a synchronization word. It then absorbs a fixed number of image bits, one per clock. During all of this it drives its serial output high.

When the local image is complete, the block switches its serial output to a copy of the input, delayed by one clock. The remaining stream then reaches the next device downstream. While the local image is incomplete, the loaded flag is low, and it is meant to hold a shared open-drain done line low. The startup trigger is a single-cycle pulse. It fires only after the wired done level reports that every device in the chain is loaded.

Top module: `cfg_chain_forwarder`

## Requirements
- R1: While `prog_n` is low, and on the first clock after it is released, `dout` is 1, `image_loaded` is 0 and `startup` is 0.
- R2: Bits before a synchronization hit are discarded. A hit requires the last `SYNC_W` bits received since program release to equal `SYNC_WORD`, with the earliest bit as MSB. A partial match does not count.
- R3: After a hit, exactly `IMAGE_BITS` further bits are absorbed. `image_loaded` rises right after the clock edge that samples the last of them. It then stays high until the next program pulse.
- R4: While `image_loaded` is low, `dout` is 1 on the following clock, whatever `din` carries.
- R5: While `image_loaded` is high, `dout` equals the `din` value sampled at the previous clock edge.
- R6: `startup` stays 0 while `done_in` is low.
- R7: `startup` is a one-clock pulse. It is raised at the edge after the first cycle in which `image_loaded` and `done_in` are both high, and it fires at most once per program pulse.
- R8: A program pulse clears the sync state, the bit count and pass-through. Bits sent afterwards without a fresh synchronization word never set `image_loaded`.
- R9: A synchronization pattern that appears in the pass-through stream is forwarded unchanged and has no effect on the local state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared configuration clock |
| prog_n | input | 1 | Shared program line, active low, synchronous clear |
| din | input | 1 | Serial configuration data in |
| done_in | input | 1 | Wired level of the shared done line |
| dout | output | 1 | Serial data to the next device |
| image_loaded | output | 1 | Local image complete; while low, the done line is pulled low |
| startup | output | 1 | One-cycle startup trigger |

## Verification
The assertions assume that `prog_n` is low at time zero and stays low for at least one clock edge, so that every register starts from a known value. They also assume that `done_in` reflects the chain only through the block's own flag. The stimulus never reports done as high while it is withholding the loaded state in a way that contradicts R6 and R7, and it changes `din`, `done_in` and `prog_n` only on falling edges. The sweeps vary the length of leading noise, insert partial synchronization prefixes and use both done levels. They also restart the chain in the middle of a load.

// File: rtl/cfgfw_pkg.sv
package cfgfw_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LOAD = 2'd1,
        ST_PASS = 2'd2
    } fw_state_e;
endpackage

// File: rtl/cfgfw_sync_hunter.sv
module cfgfw_sync_hunter #(
    parameter int              SYNC_W    = 32,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h5A3C_C3A5
) (
    input  logic clk,
    input  logic prog_n,
    input  logic din,
    input  logic hunt_en,
    output logic hit
);
    localparam int FILL_W = $clog2(SYNC_W + 1);

    typedef struct packed {
        logic [SYNC_W-1:0] win;
        logic [FILL_W-1:0] fill;
    } hunt_t;

    hunt_t hq, hd;
    logic [SYNC_W-1:0] win_next;

    always_comb begin
        win_next = {hq.win[SYNC_W-2:0], din};
        hd       = hq;
        hd.win   = win_next;
        if (hq.fill < FILL_W'(SYNC_W))
            hd.fill = hq.fill + 1'b1;
        if (!prog_n)
            hd = '0;
        hit = hunt_en && prog_n
              && (hq.fill >= FILL_W'(SYNC_W - 1))
              && (win_next == SYNC_WORD);
    end

    always_ff @(posedge clk) begin
        hq <= hd;
    end
endmodule

// File: rtl/cfgfw_startup_gate.sv
module cfgfw_startup_gate (
    input  logic clk,
    input  logic prog_n,
    input  logic loaded,
    input  logic done_in,
    output logic pulse
);
    typedef struct packed {
        logic started;
        logic pulse;
    } gate_t;

    gate_t gq, gd;

    always_comb begin
        gd.pulse   = loaded && done_in && !gq.started;
        gd.started = gq.started | gd.pulse;
        if (!prog_n)
            gd = '0;
    end

    always_ff @(posedge clk) begin
        gq <= gd;
    end

    assign pulse = gq.pulse;
endmodule

// File: rtl/cfg_chain_forwarder.sv
module cfg_chain_forwarder
    import cfgfw_pkg::*;
#(
    parameter int                SYNC_W     = 32,
    parameter logic [SYNC_W-1:0] SYNC_WORD  = 32'h5A3C_C3A5,
    parameter int                IMAGE_BITS = 64
) (
    input  logic clk,
    input  logic prog_n,
    input  logic din,
    input  logic done_in,
    output logic dout,
    output logic image_loaded,
    output logic startup
);
    localparam int CNT_W = $clog2(IMAGE_BITS + 1);

    typedef struct packed {
        fw_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             dout;
    } core_t;

    core_t cq, cd;
    logic  sync_hit;

    cfgfw_sync_hunter #(
        .SYNC_W    (SYNC_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_hunt (
        .clk     (clk),
        .prog_n  (prog_n),
        .din     (din),
        .hunt_en (cq.st == ST_HUNT),
        .hit     (sync_hit)
    );

    always_comb begin
        cd      = cq;
        cd.dout = 1'b1;
        unique case (cq.st)
            ST_HUNT: begin
                if (sync_hit) begin
                    cd.st  = ST_LOAD;
                    cd.cnt = '0;
                end
            end
            ST_LOAD: begin
                cd.cnt = cq.cnt + 1'b1;
                if (cq.cnt == CNT_W'(IMAGE_BITS - 1))
                    cd.st = ST_PASS;
            end
            ST_PASS: begin
                cd.dout = din;
            end
            default: cd.st = ST_HUNT;
        endcase
        if (!prog_n) begin
            cd.st   = ST_HUNT;
            cd.cnt  = '0;
            cd.dout = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cq <= cd;
    end

    assign dout         = cq.dout;
    assign image_loaded = (cq.st == ST_PASS);

    cfgfw_startup_gate u_gate (
        .clk     (clk),
        .prog_n  (prog_n),
        .loaded  (image_loaded),
        .done_in (done_in),
        .pulse   (startup)
    );
endmodule

// File: rtl/cfgfw_checker.sv
module cfgfw_checker (
    input logic clk,
    input logic prog_n,
    input logic din,
    input logic done_in,
    input logic dout,
    input logic image_loaded,
    input logic startup
);
    p_idle_high_r4: assert property (@(posedge clk) disable iff (!prog_n)
        !image_loaded |=> dout);

    p_forward_r5: assert property (@(posedge clk) disable iff (!prog_n)
        image_loaded |=> (dout == $past(din)));

    p_loaded_holds_r3: assert property (@(posedge clk) disable iff (!prog_n)
        image_loaded |=> image_loaded);

    p_gate_done_r6: assert property (@(posedge clk) disable iff (!prog_n)
        startup |-> ($past(done_in) && $past(image_loaded)));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!prog_n)
        startup |=> !startup);

    p_prog_clears_r8: assert property (@(posedge clk)
        !prog_n |=> (!image_loaded && dout && !startup));
endmodule

bind cfg_chain_forwarder cfgfw_checker u_chk (
    .clk          (clk),
    .prog_n       (prog_n),
    .din          (din),
    .done_in      (done_in),
    .dout         (dout),
    .image_loaded (image_loaded),
    .startup      (startup)
);

// File: tb/tb_cfg_chain_forwarder.sv
module tb_cfg_chain_forwarder;
    localparam int          IMG = 10;
    localparam logic [31:0] SW  = 32'hA5C3_0F96;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic prog_n  = 1'b0;
    logic din     = 1'b1;
    logic done_in = 1'b0;
    logic dout, image_loaded, startup;

    cfg_chain_forwarder #(
        .SYNC_W     (32),
        .SYNC_WORD  (SW),
        .IMAGE_BITS (IMG)
    ) dut (
        .clk          (clk),
        .prog_n       (prog_n),
        .din          (din),
        .done_in      (done_in),
        .dout         (dout),
        .image_loaded (image_loaded),
        .startup      (startup)
    );

    int checks = 0;
    int errors = 0;

    // requirement model
    logic [31:0] m_win;
    int          m_fill, m_state, m_cnt;
    logic        m_dout, m_start, m_started;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rnd(output logic b);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        b  = lf[0];
    endtask

    task automatic model_reset();
        m_win = '0; m_fill = 0; m_state = 0; m_cnt = 0;
        m_dout = 1'b1; m_start = 1'b0; m_started = 1'b0;
    endtask

    task automatic tick(input logic b, input logic dn, input string dtag = "");
        string dt;
        @(negedge clk);
        din = b; done_in = dn;
        m_start   = (m_state == 2) && dn && !m_started;
        m_started = m_started | m_start;
        dt        = (dtag != "") ? dtag : ((m_state == 2) ? "R5" : "R4");
        m_dout    = (m_state == 2) ? b : 1'b1;
        m_win     = {m_win[30:0], b};
        if (m_fill < 32) m_fill++;
        case (m_state)
            0: if (m_fill == 32 && m_win == SW) begin m_state = 1; m_cnt = 0; end
            1: begin m_cnt++; if (m_cnt == IMG) m_state = 2; end
            default: ;
        endcase
        @(posedge clk); #5;
        chk(dt, dout, m_dout);
        chk("R3", image_loaded, m_state == 2);
        chk(dn ? "R7" : "R6", startup, m_start);
    endtask

    task automatic do_prog();
        @(negedge clk);
        prog_n = 1'b0; din = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        model_reset();
        chk("R8", image_loaded, 1'b0);
        chk("R8", dout, 1'b1);
        chk("R8", startup, 1'b0);
        @(negedge clk);
        prog_n = 1'b1;
    endtask

    task automatic send_word(input logic [31:0] w, input int n, input logic dn,
                             input string tag = "");
        for (int i = 31; i >= 32 - n; i--) tick(w[i], dn, tag);
    endtask

    task automatic send_noise(input int n, input logic dn);
        logic b;
        for (int i = 0; i < n; i++) begin rnd(b); tick(b, dn); end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual still running expected finished");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #5;
        chk("R1", dout, 1'b1);
        chk("R1", image_loaded, 1'b0);
        chk("R1", startup, 1'b0);
        @(negedge clk);
        prog_n = 1'b1;
        tick(1'b0, 1'b0, "R1");

        // R2: noise and a partial prefix must not start loading
        send_noise(20, 1'b0);
        send_word(SW, 20, 1'b0);
        send_noise(3, 1'b0);
        chk("R2", image_loaded, 1'b0);
        send_word(SW, 32, 1'b0);
        chk("R2", m_state == 1, 1'b1);
        send_noise(IMG, 1'b0);
        chk("R3", image_loaded, 1'b1);
        // R9: sync pattern in pass stream just forwarded
        send_word(SW, 32, 1'b0, "R9");
        chk("R9", image_loaded, 1'b1);
        send_noise(16, 1'b0);
        send_noise(6, 1'b1);

        // R8: restart mid-load, then no sync
        do_prog();
        send_word(SW, 32, 1'b1);
        send_noise(IMG / 2, 1'b1);
        do_prog();
        send_noise(IMG + 40, 1'b1);
        chk("R8", image_loaded, 1'b0);

        // sweep of leading noise length and done level
        for (int lead = 0; lead <= 40; lead++) begin
            do_prog();
            send_noise(lead, lead[0]);
            send_word(SW, 32, lead[0]);
            send_noise(IMG, lead[0]);
            send_noise(4, lead[0]);
            send_noise(4, 1'b1);
        end

        summary();
        $finish;
    end
endmodule